// File: doc/BRIEF.md
# Half-Duplex Radio Receive Link

This block sits on the baseband side of a single serial data wire that is shared with a radio transceiver. In its idle state the baseband drives the wire. Software writes a control register through a small write port. When that write sets the receive-enable bit, the block stops driving the wire one clock before it acknowledges the write. The radio can then take over the wire with no overlap between the two drivers.

While receiving, the block takes the radio's data clock and the wire level through a two-flop synchronizer into the system clock domain. It samples one bit on each falling edge of the data clock, because the radio changes the wire on the rising edge. The radio may stay silent for some time after enable. While the data clock is quiet, nothing is taken. The received bits are correlated against a programmable access code of 1 to 64 bits. When every bit matches, the block strobes a found flag for one cycle. It then shifts the next 32 bits into a word and strobes a valid flag. After that it hunts for the code again.

Clearing the enable bit does not hand the wire back at once. The block waits until the radio has run one full data-clock period (a rise and then a fall) after the clear, or until a timeout expires, and only then drives the wire again.

Top module: `radio_rx_link`

## Requirements
- R1: After reset, sd_oe_o is 1, reg_ack_o is 0, sync_found_o is 0 and word_vld_o is 0.
- R2: A write to address 0 with bit 0 set drives sd_oe_o low at the first clock edge that samples the write. reg_ack_o pulses for one cycle one edge later, so the wire is released before the write completes.
- R3: While the block drives the wire, sd_o equals tx_bit_i delayed by one clock.
- R4: Bits are taken only on falling edges of dclk_i while receiving. While dclk_i does not toggle, changes on sd_i have no effect.
- R5: sync_found_o pulses for exactly one cycle when the most recent LEN received bits equal code bits [LEN-1:0]. The earliest of those bits is compared with code bit LEN-1.
- R6: LEN is programmed as LEN-1 in bits [13:8] of the address-0 write. A code that differs in any single bit gives no match.
- R7: After a match, the next 32 bits are shifted into word_o with the first bit ending in bit 31. word_vld_o then pulses for one cycle, and hunting resumes. The code is written 32 bits at a time: address 1 holds bits [31:0] and address 2 holds bits [63:32].
- R8: After a write to address 0 with bit 0 clear, sd_oe_o stays low until dclk_i has risen and then fallen, or until REL_TMO cycles have passed. It then returns high.
- R9: Writes to addresses other than 0 never change the receive-enable state.
- R10: Data clocked in before reception is enabled never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_ack_o | output | 1 | Write completion pulse |
| tx_bit_i | input | 1 | Bit to drive on the wire in drive mode |
| sd_o | output | 1 | Wire output value |
| sd_oe_o | output | 1 | Wire output enable |
| sd_i | input | 1 | Wire input value |
| dclk_i | input | 1 | Data clock from the radio |
| sync_found_o | output | 1 | Access code matched (one-cycle pulse) |
| word_o | output | WORD_W | Word received after the code |
| word_vld_o | output | 1 | word_o valid (one-cycle pulse) |

## Verification
sd_oe_o falls at the first edge that samples an enabling write, and reg_ack_o rises one edge after that. sd_o follows tx_bit_i after one edge. The bench samples each of these on the falling clock edge that follows the edge due to change it. A received bit reaches the correlator three edges after its dclk_i fall, and a match or word pulse appears at the fourth edge. The bench leaves at least five system cycles between data-clock edges and waits ten cycles after the last bit before it compares the pulse counts and the captured word. The wire returns to the baseband three edges after the closing dclk_i fall. The bench checks it eight cycles after that fall, and checks the timeout both well before and well after REL_TMO.

// File: rtl/radio_rx_pkg.sv
package radio_rx_pkg;
  typedef enum logic [1:0] {
    BUS_DRIVE   = 2'd0,
    BUS_RECV    = 2'd1,
    BUS_RELEASE = 2'd2
  } bus_st_e;

  typedef enum logic {
    HUNT_CODE    = 1'b0,
    HUNT_COLLECT = 1'b1
  } hunt_st_e;

  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_CODE0   = 1;
  localparam int unsigned CTRL_ACT_BIT = 0;
  localparam int unsigned CTRL_LEN_LSB = 8;
endpackage

// File: rtl/rx_sync_ff.sv
module rx_sync_ff #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_edge_sampler.sv
module rx_edge_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_i,
  input  logic sd_i,
  input  logic act_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_stb_o,
  output logic bit_o
);
  logic [1:0] sync_s;
  logic       dclk_s, sd_s, dclk_prev_q;
  logic       stb_q, bit_q;

  // clock and data share one synchronizer so they stay aligned
  rx_sync_ff #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dclk_i, sd_i}),
    .q_o   (sync_s)
  );

  assign dclk_s = sync_s[1];
  assign sd_s   = sync_s[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dclk_prev_q <= 1'b0;
    else         dclk_prev_q <= dclk_s;

  assign rise_o = dclk_s & ~dclk_prev_q;
  assign fall_o = ~dclk_s & dclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stb_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      stb_q <= fall_o & act_i;
      bit_q <= sd_s;
    end

  assign bit_stb_o = stb_q;
  assign bit_o     = bit_q;

  AST_STB_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> $past(act_i)); // R4
  AST_STB_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o); // R4
endmodule

// File: rtl/rx_sync_hunt.sv
module rx_sync_hunt
  import radio_rx_pkg::*;
#(
  parameter int unsigned CODE_MAX = 64,
  parameter int unsigned WORD_W   = 32,
  localparam int unsigned LEN_W   = $clog2(CODE_MAX),
  localparam int unsigned FILL_W  = $clog2(CODE_MAX + 1),
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic                bit_stb_i,
  input  logic                bit_i,
  input  logic [CODE_MAX-1:0] code_i,
  input  logic [LEN_W-1:0]    len_m1_i,
  output logic                found_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_vld_o
);
  hunt_st_e            st_q;
  logic [CODE_MAX-1:0] sh_q, sh_n, mask;
  logic [FILL_W-1:0]   fill_q, fill_n;
  logic [CNT_W-1:0]    cnt_q;
  logic [WORD_W-1:0]   word_q;
  logic                found_q, vld_q, match;

  for (genvar i = 0; i < CODE_MAX; i++) begin : g_mask
    assign mask[i] = (32'(i) <= 32'(len_m1_i));
  end

  assign sh_n   = {sh_q[CODE_MAX-2:0], bit_i};
  assign fill_n = (fill_q == FILL_W'(CODE_MAX)) ? fill_q : fill_q + 1'b1;
  assign match  = (((sh_n ^ code_i) & mask) == '0) &&
                  (fill_n > FILL_W'(len_m1_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q    <= HUNT_CODE;
      sh_q    <= '0;
      fill_q  <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      found_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (!act_i) begin
      st_q    <= HUNT_CODE;
      fill_q  <= '0;
      cnt_q   <= '0;
      found_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      found_q <= 1'b0;
      vld_q   <= 1'b0;
      if (bit_stb_i) begin
        unique case (st_q)
          HUNT_CODE: begin
            sh_q   <= sh_n;
            fill_q <= fill_n;
            if (match) begin
              found_q <= 1'b1;
              st_q    <= HUNT_COLLECT;
              cnt_q   <= '0;
              fill_q  <= '0;
            end
          end
          HUNT_COLLECT: begin
            word_q <= {word_q[WORD_W-2:0], bit_i};
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
              vld_q <= 1'b1;
              st_q  <= HUNT_CODE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= HUNT_CODE;
        endcase
      end
    end

  assign found_o    = found_q;
  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  AST_FOUND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> !found_o); // R5
  AST_FOUND_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> $past(bit_stb_i)); // R4
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o); // R7
  AST_COLLECT_AFTER_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni || !act_i)
    found_o |-> st_q == HUNT_COLLECT); // R7
  AST_NO_FOUND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> $past(act_i)); // R10
endmodule

// File: rtl/rx_bus_ctrl.sv
module rx_bus_ctrl
  import radio_rx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CODE_MAX = 64,
  parameter int unsigned REL_TMO  = 64,
  localparam int unsigned LEN_W   = $clog2(CODE_MAX),
  localparam int unsigned CODE_WORDS = (CODE_MAX + 31) / 32,
  localparam int unsigned TMO_W   = $clog2(REL_TMO + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic                reg_ack_o,
  input  logic                tx_bit_i,
  input  logic                dclk_rise_i,
  input  logic                dclk_fall_i,
  output logic                sd_o,
  output logic                sd_oe_o,
  output logic                active_o,
  output logic [CODE_MAX-1:0] code_o,
  output logic [LEN_W-1:0]    len_m1_o
);
  bus_st_e          st_q, st_n;
  logic             wr_q, ack_q, act_q, sd_q, oe_q, saw_rise_q;
  logic [LEN_W-1:0] len_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CODE_WORDS*32-1:0] code_q;
  logic             ctrl_wr, wr_on, wr_off;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_on   = ctrl_wr &&  reg_wdata_i[CTRL_ACT_BIT];
  assign wr_off  = ctrl_wr && !reg_wdata_i[CTRL_ACT_BIT];

  for (genvar k = 0; k < CODE_WORDS; k++) begin : g_code
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) code_q[k*32 +: 32] <= '0;
      else if (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CODE0 + k))
        code_q[k*32 +: 32] <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_q <= 1'b0;
      len_q <= LEN_W'(CODE_MAX - 1);
    end else if (ctrl_wr) begin
      act_q <= reg_wdata_i[CTRL_ACT_BIT];
      len_q <= reg_wdata_i[CTRL_LEN_LSB +: LEN_W];
    end

  // ack trails the capture by a cycle: the release happens inside the write
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      wr_q  <= reg_wr_i;
      ack_q <= wr_q;
    end

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      BUS_DRIVE:   if (wr_on) st_n = BUS_RECV;
      BUS_RECV:    if (wr_off) st_n = BUS_RELEASE;
      BUS_RELEASE: begin
        if (wr_on) st_n = BUS_RECV;
        else if ((saw_rise_q && dclk_fall_i) || tmo_q == TMO_W'(REL_TMO - 1))
          st_n = BUS_DRIVE;
      end
      default: st_n = BUS_DRIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q       <= BUS_DRIVE;
      oe_q       <= 1'b1;
      sd_q       <= 1'b0;
      saw_rise_q <= 1'b0;
      tmo_q      <= '0;
    end else begin
      st_q <= st_n;
      oe_q <= (st_n == BUS_DRIVE);
      sd_q <= tx_bit_i;
      if (st_q != BUS_RELEASE) begin
        saw_rise_q <= 1'b0;
        tmo_q      <= '0;
      end else begin
        if (dclk_rise_i) saw_rise_q <= 1'b1;
        tmo_q <= tmo_q + 1'b1;
      end
    end

  assign reg_ack_o = ack_q;
  assign sd_o      = sd_q;
  assign sd_oe_o   = oe_q;
  assign active_o  = (st_q == BUS_RECV);
  assign code_o    = code_q[CODE_MAX-1:0];
  assign len_m1_o  = len_q;

  AST_RELEASED_AT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_ack_o && act_q) |-> !sd_oe_o); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_ack_o) |-> $past(wr_q)); // R2
  AST_REDRIVE_ONLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_oe_o) |-> !act_q); // R8
  AST_REDRIVE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_oe_o) |-> $past(st_q) == BUS_RELEASE); // R8
endmodule

// File: rtl/radio_rx_link.sv
module radio_rx_link #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CODE_MAX = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned REL_TMO  = 64,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned LEN_W   = $clog2(CODE_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              reg_ack_o,
  input  logic              tx_bit_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i,
  input  logic              dclk_i,
  output logic              sync_found_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic                active, rise, fall, bit_stb, bit_v;
  logic [CODE_MAX-1:0] code;
  logic [LEN_W-1:0]    len_m1;

  rx_bus_ctrl #(
    .ADDR_W(ADDR_W), .CODE_MAX(CODE_MAX), .REL_TMO(REL_TMO)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_ack_o  (reg_ack_o),
    .tx_bit_i   (tx_bit_i),
    .dclk_rise_i(rise),
    .dclk_fall_i(fall),
    .sd_o       (sd_o),
    .sd_oe_o    (sd_oe_o),
    .active_o   (active),
    .code_o     (code),
    .len_m1_o   (len_m1)
  );

  rx_edge_sampler #(.STAGES(SYNC_STG)) u_samp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dclk_i   (dclk_i),
    .sd_i     (sd_i),
    .act_i    (active),
    .rise_o   (rise),
    .fall_o   (fall),
    .bit_stb_o(bit_stb),
    .bit_o    (bit_v)
  );

  rx_sync_hunt #(.CODE_MAX(CODE_MAX), .WORD_W(WORD_W)) u_hunt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (active),
    .bit_stb_i (bit_stb),
    .bit_i     (bit_v),
    .code_i    (code),
    .len_m1_i  (len_m1),
    .found_o   (sync_found_o),
    .word_o    (word_o),
    .word_vld_o(word_vld_o)
  );

  AST_NO_DRIVE_WHILE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> !sd_oe_o); // R2
endmodule

// File: tb/tb_radio_rx_link.sv
module tb_radio_rx_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ack;
  logic        tx_bit = 1'b0;
  logic        sd_out, sd_oe;
  logic        sd_in = 1'b0;
  logic        dclk = 1'b0;
  logic        found;
  logic [31:0] word;
  logic        word_vld;

  int checks = 0;
  int fails  = 0;
  int found_cnt = 0;
  int vld_cnt = 0;
  logic [31:0] last_word = '0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  radio_rx_link dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_ack_o(reg_ack), .tx_bit_i(tx_bit), .sd_o(sd_out), .sd_oe_o(sd_oe),
    .sd_i(sd_in), .dclk_i(dclk), .sync_found_o(found), .word_o(word),
    .word_vld_o(word_vld)
  );

  always @(negedge clk) begin
    if (found) found_cnt++;
    if (word_vld) begin
      vld_cnt++;
      last_word = word;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // radio changes data on rising dclk, baseband samples on falling
  task automatic send_bit(input logic b);
    @(negedge clk);
    dclk = 1'b1; sd_in = b;
    idle(5);
    dclk = 1'b0;
    idle(5);
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic t_reset;
    check(sd_oe === 1'b1, "R1 oe", 64'(sd_oe), 1);
    check(reg_ack === 1'b0, "R1 ack", 64'(reg_ack), 0);
    check(found === 1'b0 && word_vld === 1'b0, "R1 pulses", 64'({found, word_vld}), 0);
  endtask

  task automatic t_drive_mode;
    @(negedge clk); tx_bit = 1'b1;
    @(negedge clk);
    check(sd_out === 1'b1, "R3 tx high", 64'(sd_out), 1);
    tx_bit = 1'b0;
    @(negedge clk);
    check(sd_out === 1'b0, "R3 tx low", 64'(sd_out), 0);
  endtask

  task automatic t_other_addr;
    wr(4'd3, 32'h1);
    idle(2);
    check(sd_oe === 1'b1, "R9 no activate", 64'(sd_oe), 1);
  endtask

  task automatic t_pre_activation(input logic [63:0] code);
    int f0 = found_cnt;
    send_bits(code, 64);
    idle(10);
    check(found_cnt == f0, "R10 no match before enable", 64'(found_cnt - f0), 0);
  endtask

  task automatic t_activate;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0000_3F01;
    @(negedge clk);
    reg_wr = 1'b0;
    check(sd_oe === 1'b0, "R2 released at first edge", 64'(sd_oe), 0);
    check(reg_ack === 1'b0, "R2 ack not yet", 64'(reg_ack), 0);
    @(negedge clk);
    check(reg_ack === 1'b1, "R2 ack follows", 64'(reg_ack), 1);
    check(sd_oe === 1'b0, "R2 still released", 64'(sd_oe), 0);
    @(negedge clk);
    check(reg_ack === 1'b0, "R2 ack one cycle", 64'(reg_ack), 0);
  endtask

  task automatic t_quiet_gap;
    int f0 = found_cnt;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sd_in = ~sd_in;
    end
    idle(10);
    check(found_cnt == f0, "R4 idle clock ignored", 64'(found_cnt - f0), 0);
  endtask

  task automatic t_match64(input logic [63:0] code);
    int f0 = found_cnt;
    int v0 = vld_cnt;
    send_bits(64'h53, 8);
    send_bits(code, 64);
    idle(10);
    check(found_cnt == f0 + 1, "R5 64-bit match", 64'(found_cnt - f0), 1);
    send_bits(64'h1234ABCD, 32);
    idle(10);
    check(vld_cnt == v0 + 1, "R7 word valid", 64'(vld_cnt - v0), 1);
    check(last_word == 32'h1234ABCD, "R7 word value", 64'(last_word), 64'h1234ABCD);
  endtask

  task automatic t_short_code;
    int f0, v0;
    wr(4'd1, 32'h0000_00B4);
    wr(4'd0, 32'h0000_0701);
    f0 = found_cnt;
    send_bits(64'h0, 8);
    send_bits(64'hB5, 8);
    send_bits(64'h0, 8);
    idle(10);
    check(found_cnt == f0, "R6 near miss rejected", 64'(found_cnt - f0), 0);
    v0 = vld_cnt;
    send_bits(64'hB4, 8);
    idle(10);
    check(found_cnt == f0 + 1, "R6 8-bit match", 64'(found_cnt - f0), 1);
    send_bits(64'hDEADBEEF, 32);
    idle(10);
    check(vld_cnt == v0 + 1 && last_word == 32'hDEADBEEF, "R7 short word", 64'(last_word), 64'hDEADBEEF);
  endtask

  task automatic t_resume;
    int f0 = found_cnt;
    int v0 = vld_cnt;
    send_bits(64'hB4, 8);
    send_bits(64'h0F0F_A5A5, 32);
    send_bits(64'h0, 4);
    send_bits(64'hB4, 8);
    send_bits(64'h8000_0001, 32);
    idle(10);
    check(found_cnt == f0 + 2, "R7 hunt resumes", 64'(found_cnt - f0), 2);
    check(vld_cnt == v0 + 2 && last_word == 32'h8000_0001, "R7 second word", 64'(last_word), 64'h8000_0001);
  endtask

  task automatic t_release_clock;
    wr(4'd0, 32'h0000_0700);
    idle(20);
    check(sd_oe === 1'b0, "R8 held until radio clock", 64'(sd_oe), 0);
    @(negedge clk); dclk = 1'b1;
    idle(5);
    dclk = 1'b0;
    idle(8);
    check(sd_oe === 1'b1, "R8 redrive after period", 64'(sd_oe), 1);
  endtask

  task automatic t_release_timeout;
    wr(4'd0, 32'h0000_0701);
    idle(3);
    check(sd_oe === 1'b0, "R2 re-enable released", 64'(sd_oe), 0);
    wr(4'd0, 32'h0000_0700);
    idle(30);
    check(sd_oe === 1'b0, "R8 before timeout", 64'(sd_oe), 0);
    idle(45);
    check(sd_oe === 1'b1, "R8 after timeout", 64'(sd_oe), 1);
  endtask

  initial begin
    logic [63:0] code64 = 64'hA5C3_0F96_5A3C_E187;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_drive_mode();
    t_other_addr();
    wr(4'd1, code64[31:0]);
    wr(4'd2, code64[63:32]);
    t_pre_activation(code64);
    t_activate();
    t_quiet_gap();
    t_match64(code64);
    t_short_code();
    t_resume();
    t_release_clock();
    t_release_timeout();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
      end
      wait (done);
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule